// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the command engine of one I2C master channel, working at byte level. Software writes a command word whose flags ask for any mix of a start (with address), a single data byte sent, a byte received, and a stop. The engine runs the requested phases one after another against an abstract byte-level bus port. That port carries one operation at a time: start with address, send byte, receive byte, or end transfer. Each operation uses a valid/ready handshake and returns an ack/nak result or a received byte.

A 4-bit state code shows where the engine is. Sticky event bits record ack, nak, receive-done, normal stop and abnormal stop. They are cleared by writing ones to them. Bit-level line timing, slave operation, arbitration and the buffered or DMA byte sources are outside the block. The single transmit byte comes from a byte-provider input, `tx_byte_i`.

Top module: `i2c_mseq`

## Requirements
- R1: A command write is taken only when `en_i` is high and the engine is idle. `busy_o` goes high the cycle after a write is taken and stays high until the last phase completes. A write made while disabled or busy has no effect.
- R2: `cmd_o` holds the written command bits [15:0]. The flag positions are start = bit 0, transmit = bit 1, receive = bit 3, receive-last = bit 4 and stop = bit 5. Each flag clears itself when its phase completes.
- R3: Within one command, the phases run in the order start, transmit, receive, stop. Each phase issues its bus operation with `op_valid_o` and holds it until `op_ready_i`. Operation codes: 0 = start, 1 = send, 2 = receive, 3 = end transfer.
- R4: The start phase shows state 0xA if bit 3 of the current state is set, and 0x9 otherwise. It sends `tx_byte_i` as the address byte: target address in bits [7:1], direction in bit 0. A nak result sets the nak event and an ack result sets the ack event.
- R5: A start clears the transmit flag, because the address used the single byte. If `bus_busy_i` is low when the start completes, all later phases are skipped, their flags stay set and the state remains at the start code. Otherwise the state becomes 0x8.
- R6: The transmit phase shows state 0xC and sends `tx_byte_i`. On ack it sets the ack event. On nak it sets the nak event and then issues an end-transfer operation. In both cases the state returns to 0x8.
- R7: The receive phase (receive or receive-last flag) runs only while the receive-done event is clear. Otherwise no operation is issued and the flags stay set. It shows state 0xE, asks for a nack answer exactly when receive-last is set, stores the byte on `rx_data_o`, sets receive-done and returns to 0x8.
- R8: A stop while state bit 3 is clear issues no operation and sets the abnormal event. Otherwise it shows state 0xB, issues end transfer and sets the normal-stop event. In both cases the state then becomes 0x0.
- R9: The event bits on `evt_o` are ack = 0, nak = 1, receive-done = 2, normal stop = 3, abnormal stop = 4. They are 0 after reset and stay set until a one is written to `evt_clr_i` at their position. Bits not written keep their value, and a new event wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enabled (master or slave enable set) |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 16 | Command word |
| tx_byte_i | input | 8 | Byte provider: address or data byte |
| evt_clr_i | input | 5 | Write-one-to-clear mask for events |
| op_valid_o | output | 1 | Bus operation requested |
| op_code_o | output | 2 | Bus operation code |
| op_byte_o | output | 8 | Byte for start or send |
| op_nack_o | output | 1 | Answer the received byte with nack |
| op_ready_i | input | 1 | Bus operation completes |
| op_nak_i | input | 1 | Start or send was not acknowledged |
| op_rdata_i | input | 8 | Received byte |
| bus_busy_i | input | 1 | Bus holds an open transfer |
| busy_o | output | 1 | Command in progress |
| state_o | output | 4 | State code |
| cmd_o | output | 16 | Command register bits [15:0] |
| rx_data_o | output | 8 | Last received byte |
| evt_o | output | 5 | Sticky events |

## Verification
A scoreboard predicts every bus operation, including the state code shown while it is in flight. Any missing, extra or reordered operation is therefore reported, for example a send issued after a start or a receive issued while receive-done is pending. Repeated-start coding is exercised from the active state. A start that finds the bus idle must leave the stop flag set and the state at 0x9. A later stop from that state must still be a normal one. A stop from idle must give an abnormal event with no bus traffic. A write made during a chained command must be dropped: a design that took it would add an abnormal stop to the event bits.

// File: rtl/i2c_mseq_pkg.sv
package i2c_mseq_pkg;
  localparam int FLG_START = 0;
  localparam int FLG_TX    = 1;
  localparam int FLG_RX    = 3;
  localparam int FLG_LAST  = 4;
  localparam int FLG_STOP  = 5;

  localparam int EVT_ACK  = 0;
  localparam int EVT_NAK  = 1;
  localparam int EVT_RX   = 2;
  localparam int EVT_STOP = 3;
  localparam int EVT_ABN  = 4;
  localparam int EVT_N    = 5;

  localparam logic [3:0] ST_IDLE   = 4'h0;
  localparam logic [3:0] ST_ACTIVE = 4'h8;
  localparam logic [3:0] ST_START  = 4'h9;
  localparam logic [3:0] ST_RSTART = 4'hA;
  localparam logic [3:0] ST_STOP   = 4'hB;
  localparam logic [3:0] ST_TXD    = 4'hC;
  localparam logic [3:0] ST_RXD    = 4'hE;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_END   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DISP, PH_START, PH_TX, PH_TXEND, PH_RX, PH_STOP
  } phase_e;
endpackage

// File: rtl/i2c_mseq_evt.sv
module i2c_mseq_evt
  import i2c_mseq_pkg::*;
#(
  parameter int N = EVT_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (evt_q & ~clr_i) | set_i;
  end

  assign evt_o = evt_q;

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_q & $past(clr_i & ~set_i)) == '0)); // R9
  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_q & $past(set_i)) == $past(set_i))); // R9
endmodule

// File: rtl/i2c_mseq_ctrl.sv
module i2c_mseq_ctrl
  import i2c_mseq_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int DATA_W = 8,
  parameter int ST_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              rx_pend_i,
  output logic              op_valid_o,
  output logic [1:0]        op_code_o,
  output logic [DATA_W-1:0] op_byte_o,
  output logic              op_nack_o,
  input  logic              op_ready_i,
  input  logic              op_nak_i,
  input  logic [DATA_W-1:0] op_rdata_i,
  input  logic              bus_busy_i,
  output logic [EVT_N-1:0]  evt_set_o,
  output logic              busy_o,
  output logic [ST_W-1:0]   state_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int ACT_BIT = ST_W - 1;

  phase_e             ph_q, ph_d;
  logic [ST_W-1:0]    st_q, st_d;
  logic [CMD_W-1:0]   cmd_q, cmd_d;
  logic [DATA_W-1:0]  rx_q, rx_d;
  logic               rx_req, fire;

  assign rx_req = cmd_q[FLG_RX] | cmd_q[FLG_LAST];
  assign fire   = op_valid_o & op_ready_i;

  always_comb begin
    ph_d      = ph_q;
    st_d      = st_q;
    cmd_d     = cmd_q;
    rx_d      = rx_q;
    evt_set_o = '0;
    unique case (ph_q)
      PH_IDLE: if (cmd_we_i && en_i) begin
        cmd_d = cmd_wdata_i;
        ph_d  = PH_DISP;
      end
      PH_DISP: begin
        if (cmd_q[FLG_START]) begin
          st_d = st_q[ACT_BIT] ? ST_RSTART : ST_START;
          ph_d = PH_START;
        end else if (cmd_q[FLG_TX]) begin
          st_d = ST_TXD;
          ph_d = PH_TX;
        end else if (rx_req && !rx_pend_i) begin
          st_d = ST_RXD;
          ph_d = PH_RX;
        end else if (cmd_q[FLG_STOP]) begin
          if (st_q[ACT_BIT]) begin
            st_d = ST_STOP;
            ph_d = PH_STOP;
          end else begin
            evt_set_o[EVT_ABN] = 1'b1;
            cmd_d[FLG_STOP]    = 1'b0;
            st_d               = ST_IDLE;
          end
        end else begin
          ph_d = PH_IDLE;
        end
      end
      PH_START: if (fire) begin
        evt_set_o[op_nak_i ? EVT_NAK : EVT_ACK] = 1'b1;
        cmd_d[FLG_START] = 1'b0;
        cmd_d[FLG_TX]    = 1'b0;  // single byte went out as address
        if (bus_busy_i) begin
          st_d = ST_ACTIVE;
          ph_d = PH_DISP;
        end else begin
          ph_d = PH_IDLE;
        end
      end
      PH_TX: if (fire) begin
        if (op_nak_i) begin
          evt_set_o[EVT_NAK] = 1'b1;
          ph_d = PH_TXEND;
        end else begin
          evt_set_o[EVT_ACK] = 1'b1;
          cmd_d[FLG_TX] = 1'b0;
          st_d = ST_ACTIVE;
          ph_d = PH_DISP;
        end
      end
      PH_TXEND: if (fire) begin
        cmd_d[FLG_TX] = 1'b0;
        st_d = ST_ACTIVE;
        ph_d = PH_DISP;
      end
      PH_RX: if (fire) begin
        rx_d = op_rdata_i;
        evt_set_o[EVT_RX] = 1'b1;
        cmd_d[FLG_RX]   = 1'b0;
        cmd_d[FLG_LAST] = 1'b0;
        st_d = ST_ACTIVE;
        ph_d = PH_DISP;
      end
      PH_STOP: if (fire) begin
        evt_set_o[EVT_STOP] = 1'b1;
        cmd_d[FLG_STOP] = 1'b0;
        st_d = ST_IDLE;
        ph_d = PH_DISP;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      st_q  <= ST_IDLE;
      cmd_q <= '0;
      rx_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      st_q  <= st_d;
      cmd_q <= cmd_d;
      rx_q  <= rx_d;
    end
  end

  always_comb begin
    op_valid_o = 1'b1;
    op_code_o  = OP_END;
    op_byte_o  = '0;
    unique case (ph_q)
      PH_START: begin op_code_o = OP_START; op_byte_o = tx_byte_i; end
      PH_TX:    begin op_code_o = OP_SEND;  op_byte_o = tx_byte_i; end
      PH_RX:    op_code_o = OP_RECV;
      PH_TXEND, PH_STOP: op_code_o = OP_END;
      default:  op_valid_o = 1'b0;
    endcase
  end

  assign op_nack_o = (ph_q == PH_RX) & cmd_q[FLG_LAST];
  assign busy_o    = (ph_q != PH_IDLE);
  assign state_o   = st_q;
  assign cmd_o     = cmd_q;
  assign rx_data_o = rx_q;

  AST_IDLE_NO_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !op_valid_o); // R1
  AST_OP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && !op_ready_i |=> op_valid_o && $stable(op_code_o) && $stable(op_byte_o)); // R3
  AST_START_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && op_code_o == OP_START |-> (st_q == ST_START || st_q == ST_RSTART)); // R4
  AST_RX_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(op_valid_o) && op_code_o == OP_RECV |-> !rx_pend_i); // R7
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_STOP && fire |=> st_q == ST_IDLE); // R8
endmodule

// File: rtl/i2c_mseq.sv
module i2c_mseq
  import i2c_mseq_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int DATA_W = 8,
  parameter int ST_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic [EVT_N-1:0]  evt_clr_i,
  output logic              op_valid_o,
  output logic [1:0]        op_code_o,
  output logic [DATA_W-1:0] op_byte_o,
  output logic              op_nack_o,
  input  logic              op_ready_i,
  input  logic              op_nak_i,
  input  logic [DATA_W-1:0] op_rdata_i,
  input  logic              bus_busy_i,
  output logic              busy_o,
  output logic [ST_W-1:0]   state_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [EVT_N-1:0]  evt_o
);
  logic [EVT_N-1:0] evt_set;

  i2c_mseq_ctrl #(.CMD_W(CMD_W), .DATA_W(DATA_W), .ST_W(ST_W)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .cmd_we_i, .cmd_wdata_i, .tx_byte_i,
    .rx_pend_i (evt_o[EVT_RX]),
    .op_valid_o, .op_code_o, .op_byte_o, .op_nack_o,
    .op_ready_i, .op_nak_i, .op_rdata_i, .bus_busy_i,
    .evt_set_o (evt_set),
    .busy_o, .state_o, .cmd_o, .rx_data_o
  );

  i2c_mseq_evt #(.N(EVT_N)) u_evt (
    .clk_i, .rst_ni,
    .set_i (evt_set),
    .clr_i (evt_clr_i),
    .evt_o
  );
endmodule

// File: tb/i2c_mseq_tb_top.sv
module i2c_mseq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic        cmd_we_i = 1'b0;
  logic [15:0] cmd_wdata_i = '0;
  logic [7:0]  tx_byte_i = '0;
  logic [4:0]  evt_clr_i = '0;
  logic        op_valid_o, op_nack_o, op_ready_i = 1'b0, op_nak_i = 1'b0, bus_busy_i = 1'b1;
  logic [1:0]  op_code_o;
  logic [7:0]  op_byte_o, op_rdata_i = '0, rx_data_o;
  logic        busy_o;
  logic [3:0]  state_o;
  logic [15:0] cmd_o;
  logic [4:0]  evt_o;

  int n_run = 0, n_fail = 0, cyc = 0;

  typedef struct {
    logic [1:0] code;
    logic [7:0] data;
    logic       nack;
    logic [3:0] st;
    logic       resp_nak;
    logic [7:0] resp_data;
    string      req;
  } item_t;
  item_t exp_q[$];

  always #10 clk_i = ~clk_i;

  i2c_mseq dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [1:0] code, logic [7:0] data, logic nack, logic [3:0] st,
                      logic rn, logic [7:0] rd, string req);
    item_t it;
    it.code = code; it.data = data; it.nack = nack; it.st = st;
    it.resp_nak = rn; it.resp_data = rd; it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor / bus model
  always @(negedge clk_i) begin
    cyc++;
    if (op_valid_o && !op_ready_i) begin
      if (exp_q.size() == 0) begin
        chk("R3", {op_code_o, op_byte_o}, 32'hFFFF, "unexpected op");
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(it.req, op_code_o, it.code, "op code");
        if (it.code <= 2'd1) chk(it.req, op_byte_o, it.data, "op byte");
        if (it.code == 2'd2) chk(it.req, op_nack_o, it.nack, "op nack");
        chk(it.req, state_o, it.st, "state during op");
        op_nak_i   = it.resp_nak;
        op_rdata_i = it.resp_data;
      end
      op_ready_i = 1'b1;
    end else begin
      op_ready_i = 1'b0;
    end
  end

  task automatic issue(logic [15:0] w);
    @(negedge clk_i);
    cmd_wdata_i = w;
    cmd_we_i    = 1'b1;
    @(negedge clk_i);
    cmd_we_i    = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int t = 0;
    while (busy_o && t < 200) begin
      @(negedge clk_i);
      t++;
    end
    repeat (2) @(negedge clk_i);
    chk(req, busy_o, 1'b0, "busy after command");
    chk(req, exp_q.size(), 0, "ops outstanding");
  endtask

  task automatic clear(logic [4:0] m);
    @(negedge clk_i);
    evt_clr_i = m;
    @(negedge clk_i);
    evt_clr_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", busy_o, 1'b0, "reset busy");
    chk("R8", state_o, 4'h0, "reset state");
    chk("R9", evt_o, 5'h00, "reset events");
    chk("R2", cmd_o, 16'h0000, "reset cmd");

    // R1: disabled channel ignores writes
    en_i = 1'b0;
    issue(16'h0021);
    repeat (3) @(negedge clk_i);
    chk("R1", busy_o, 1'b0, "busy while disabled");
    chk("R1", cmd_o, 16'h0000, "cmd while disabled");
    en_i = 1'b1;

    // R4/R8: start + stop
    tx_byte_i = 8'hA4;
    push(2'd0, 8'hA4, 1'b0, 4'h9, 1'b0, 8'h00, "R4");
    push(2'd3, 8'h00, 1'b0, 4'hB, 1'b0, 8'h00, "R8");
    issue(16'h0021);
    chk("R1", busy_o, 1'b1, "busy after accept");
    wait_idle("R3");
    chk("R8", evt_o, 5'h09, "ack+stop events");
    chk("R8", state_o, 4'h0, "idle after stop");
    chk("R2", cmd_o, 16'h0000, "flags self-cleared");
    clear(5'h1F);
    chk("R9", evt_o, 5'h00, "cleared");

    // R6: transmit alone, ack
    tx_byte_i = 8'h5C;
    push(2'd1, 8'h5C, 1'b0, 4'hC, 1'b0, 8'h00, "R6");
    issue(16'h0002);
    wait_idle("R6");
    chk("R6", evt_o, 5'h01, "tx ack event");
    chk("R6", state_o, 4'h8, "active after tx");
    clear(5'h1F);

    // R4: repeated start from active, nak
    tx_byte_i = 8'h31;
    push(2'd0, 8'h31, 1'b0, 4'hA, 1'b1, 8'h00, "R4");
    issue(16'h0001);
    wait_idle("R4");
    chk("R4", evt_o, 5'h02, "address nak event");
    chk("R5", state_o, 4'h8, "active after start");
    clear(5'h1F);

    // R6: transmit nak ends transfer
    tx_byte_i = 8'hE7;
    push(2'd1, 8'hE7, 1'b0, 4'hC, 1'b1, 8'h00, "R6");
    push(2'd3, 8'h00, 1'b0, 4'hC, 1'b0, 8'h00, "R6");
    issue(16'h0002);
    wait_idle("R6");
    chk("R6", evt_o, 5'h02, "tx nak event");
    chk("R6", state_o, 4'h8, "active after tx nak");
    chk("R2", cmd_o, 16'h0000, "tx flag cleared");
    clear(5'h1F);

    // R7: receive-last
    push(2'd2, 8'h00, 1'b1, 4'hE, 1'b0, 8'h3B, "R7");
    issue(16'h0018);
    wait_idle("R7");
    chk("R7", rx_data_o, 8'h3B, "rx data");
    chk("R7", evt_o, 5'h04, "rx done event");
    chk("R7", state_o, 4'h8, "active after rx");

    // R7: receive blocked while rx-done pending
    issue(16'h0008);
    wait_idle("R7");
    chk("R7", cmd_o, 16'h0008, "rx flag kept while pending");
    chk("R7", rx_data_o, 8'h3B, "rx data unchanged");
    clear(5'h1F);

    // R3/R5/R1: chain; transmit dropped; write during busy dropped
    tx_byte_i = 8'h91;
    push(2'd0, 8'h91, 1'b0, 4'hA, 1'b0, 8'h00, "R3");
    push(2'd2, 8'h00, 1'b0, 4'hE, 1'b0, 8'h66, "R3");
    push(2'd3, 8'h00, 1'b0, 4'hB, 1'b0, 8'h00, "R3");
    issue(16'h002B);
    issue(16'h0020);
    wait_idle("R3");
    chk("R1", evt_o, 5'h0D, "chain events, busy write dropped");
    chk("R3", rx_data_o, 8'h66, "chain rx data");
    chk("R8", state_o, 4'h0, "idle after chain");
    chk("R2", cmd_o, 16'h0000, "chain flags cleared");
    clear(5'h1F);

    // R8: stop from idle is abnormal
    issue(16'h0020);
    wait_idle("R8");
    chk("R8", evt_o, 5'h10, "abnormal stop event");
    chk("R8", state_o, 4'h0, "idle after abnormal");
    clear(5'h1F);

    // R5: bus not busy after start skips the rest
    bus_busy_i = 1'b0;
    tx_byte_i  = 8'h20;
    push(2'd0, 8'h20, 1'b0, 4'h9, 1'b0, 8'h00, "R5");
    issue(16'h0023);
    wait_idle("R5");
    chk("R5", state_o, 4'h9, "state left at start");
    chk("R5", cmd_o, 16'h0020, "tx dropped, stop kept");
    chk("R5", evt_o, 5'h01, "start ack only");

    // R9: partial clear keeps other bits
    clear(5'h02);
    chk("R9", evt_o, 5'h01, "unwritten bit kept");
    bus_busy_i = 1'b1;

    // R8: stop from start state is normal
    push(2'd3, 8'h00, 1'b0, 4'hB, 1'b0, 8'h00, "R8");
    issue(16'h0020);
    wait_idle("R8");
    chk("R8", evt_o, 5'h09, "normal stop from start state");
    chk("R8", state_o, 4'h0, "idle");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule